// File: doc/BRIEF.md
# Ingress Traffic-Class Classifier

This block watches the header of each incoming Ethernet frame as it streams in one byte per beat. From the destination address, the type field and an optional priority tag, it picks one of eight traffic classes for the frame. It reports that class with a one-cycle done strobe as soon as enough of the header has arrived. Two configuration inputs steer the decision. One is the 16-bit type value that counts as a priority tag. The other is the class given to frames that carry no recognised tag.

Two address prefixes mark management frames. Such frames always go to the highest class, whatever their tag says. Because the tag type is programmable, a port can be set to look for a private tag value. Frames with the ordinary 0x8100 tag are then classed as untagged. The block only parses the header. It stores nothing past the decision and ignores payload bytes until the next frame begins.

Top module: `frame_tc_classifier`

## Requirements
- R1: After a synchronous active-low reset, `tc_done` is 0 and `tc_class` is 0.
- R2: Bytes are indexed from 0 at the beat that carries `in_sof`. When bytes 12 and 13, with byte 12 as the high byte, equal `cfg_vlan_type`, the frame is tagged. Its class is bits 7:5 of byte 14, and the decision is made on byte 14.
- R3: When bytes 12 and 13 do not equal `cfg_vlan_type`, the class is `cfg_port_class`, and the decision is made on byte 13.
- R4: With `cfg_vlan_type` set to a value other than 0x8100, a frame carrying 0x8100 in bytes 12 and 13 is classed as untagged (R3).
- R5: A frame whose bytes 0 to 2 are 01-80-C2 or 01-19-1B is a management frame. It gets class 7 on byte 13, whatever its type field or priority bits.
- R6: If `in_eof` arrives with a byte before a decision can be made, the class is `cfg_port_class` and the decision is made on that last byte. This includes a tagged frame that ends on byte 13.
- R7: Exactly one decision is made per frame. Bytes after the decision, and valid bytes outside any frame, cause no strobe and leave `tc_class` unchanged.
- R8: `in_sof` on any valid byte abandons the frame in progress and starts parsing that byte as byte 0.
- R9: `tc_done` is high for exactly the one cycle after the clock edge that samples the deciding byte. `tc_class` carries the result from that cycle and holds it until the next decision. Idle cycles (`in_valid` low) never raise `tc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A header byte is present this cycle |
| in_sof | input | 1 | Present byte is the first of a frame |
| in_eof | input | 1 | Present byte is the last of a frame |
| in_byte | input | 8 | Header byte |
| cfg_vlan_type | input | 16 | Type value recognised as a priority tag |
| cfg_port_class | input | 3 | Class for frames without a recognised tag |
| tc_class | output | 3 | Chosen traffic class |
| tc_done | output | 1 | One-cycle strobe: `tc_class` is new |

## Verification
The bench builds the block with its default parameters. These give two management prefixes of three bytes each, six-byte addresses and a three-bit class, so the management class is 7. With these values, every decision point and the full management override can be reached in frames of at most a few dozen bytes. The bench switches the tag type between 0x8100 and a private value while the run is in progress. It also mixes near-miss prefixes, gaps in the byte stream, truncated frames, mid-frame restarts and stray bytes outside any frame.

// File: rtl/tcc_pkg.sv
// Package: shared constants and types for the traffic-class classifier.
// Assumes byte-wide header streaming and a 16-bit type field.
package tcc_pkg;
    localparam int BYTE_W = 8;
    localparam int TYPE_W = 16;

    // Where a decision came from; used inside the decider.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_DEFAULT = 2'd1,
        SRC_MGMT    = 2'd2,
        SRC_TAG     = 2'd3
    } tc_src_e;
endpackage

// File: rtl/tcc_hdr_pos.sv
// Module: tracks the byte position within the current frame header.
// Assumes in_sof marks byte 0. Position saturates at POS_MAX. Parsing is
// active from the sof byte until the decider raises 'stop'.
module tcc_hdr_pos #(
    parameter int POS_MAX = 14,
    localparam int IDX_W  = $clog2(POS_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             stop,
    output logic             beat,
    output logic [IDX_W-1:0] cur_idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(POS_MAX);

    logic             active_q;
    logic [IDX_W-1:0] pos_q;

    // A byte counts when it opens a frame or arrives while parsing is active.
    assign beat    = in_valid && (in_sof || active_q);
    assign cur_idx = in_sof ? '0 : pos_q;

    // Advance the position and keep the activity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pos_q    <= '0;
        end else if (beat) begin
            active_q <= !stop;
            pos_q    <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        end
    end

    a_r7_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= IDX_MAX);
endmodule

// File: rtl/tcc_mgmt_match.sv
// Module: detects management destination prefixes on the first header bytes.
// Assumes prefixes are packed, most significant byte first, prefix 0 lowest.
// 'hit' is meaningful once byte PREFIX_BYTES-1 of the frame has been seen.
module tcc_mgmt_match #(
    parameter int NUM_PREFIX   = 2,
    parameter int PREFIX_BYTES = 3,
    parameter logic [NUM_PREFIX*PREFIX_BYTES*8-1:0] PREFIX_LIST = 48'h01191B_0180C2,
    parameter int IDX_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [7:0]       in_byte,
    output logic             hit
);
    logic [NUM_PREFIX-1:0] match_q;

    for (genvar k = 0; k < NUM_PREFIX; k++) begin : g_prefix
        // Running compare of the leading bytes against prefix k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q[k] <= 1'b0;
            end else if (beat) begin
                for (int j = 0; j < PREFIX_BYTES; j++) begin
                    if (cur_idx == IDX_W'(j)) begin
                        match_q[k] <= ((j == 0) ? 1'b1 : match_q[k]) &&
                            (in_byte == PREFIX_LIST[(k*PREFIX_BYTES + PREFIX_BYTES-1-j)*8 +: 8]);
                    end
                end
            end
        end
    end

    assign hit = |match_q;
endmodule

// File: rtl/tcc_type_match.sv
// Module: compares the two-byte type field with the configured tag type.
// Assumes the high byte comes first, at index HI_IDX. 'type_hit' is valid on
// the beat carrying byte HI_IDX+1.
module tcc_type_match #(
    parameter int HI_IDX = 12,
    parameter int IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat,
    input  logic [IDX_W-1:0]          cur_idx,
    input  logic [7:0]                in_byte,
    input  logic [tcc_pkg::TYPE_W-1:0] cfg_type,
    output logic                      type_hit
);
    localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(HI_IDX);

    logic [7:0] hi_q;

    // Capture the high type byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_q <= '0;
        else if (beat && cur_idx == IDX_HI)   hi_q <= in_byte;
    end

    // Full compare once the low byte is on the bus.
    assign type_hit = ({hi_q, in_byte} == cfg_type);
endmodule

// File: rtl/tcc_class_decide.sv
// Module: chooses the class and registers the result with a done strobe.
// Assumes cur_idx/beat from the position tracker, a management flag already
// settled by the type-field byte, and a type match valid on that byte.
module tcc_class_decide #(
    parameter int CLASS_W = 3,
    parameter int LO_IDX  = 13,
    parameter int TAG_IDX = 14,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               beat,
    input  logic [IDX_W-1:0]   cur_idx,
    input  logic               in_eof,
    input  logic [CLASS_W-1:0] prio_field,
    input  logic               mgmt_hit,
    input  logic               type_hit,
    input  logic [CLASS_W-1:0] cfg_default,
    output logic               stop,
    output logic [CLASS_W-1:0] class_out,
    output logic               class_done
);
    import tcc_pkg::*;

    localparam logic [IDX_W-1:0]   IDX_LO    = IDX_W'(LO_IDX);
    localparam logic [IDX_W-1:0]   IDX_TAG   = IDX_W'(TAG_IDX);
    localparam logic [CLASS_W-1:0] MGMT_CLASS = '1;

    tc_src_e            src;
    logic               go_wait;
    logic               wait_q;
    logic [CLASS_W-1:0] class_q;
    logic               done_q;

    // Decide the source of the class for the present byte.
    always_comb begin
        src     = SRC_NONE;
        go_wait = 1'b0;
        if (beat) begin
            if (cur_idx == IDX_LO) begin
                if (mgmt_hit)                  src = SRC_MGMT;
                else if (!type_hit || in_eof)  src = SRC_DEFAULT;
                else                           go_wait = 1'b1;
            end else if (cur_idx == IDX_TAG && wait_q) begin
                src = SRC_TAG;
            end else if (in_eof) begin
                src = SRC_DEFAULT;
            end
        end
    end

    assign stop = (src != SRC_NONE) || (beat && in_eof);

    // Remember that the tag control byte is awaited.
    always_ff @(posedge clk) begin
        if (!rst_n)    wait_q <= 1'b0;
        else if (beat) wait_q <= go_wait;
    end

    // Register the chosen class and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (src != SRC_NONE);
            case (src)
                SRC_MGMT:    class_q <= MGMT_CLASS;
                SRC_DEFAULT: class_q <= cfg_default;
                SRC_TAG:     class_q <= prio_field;
                default:     class_q <= class_q;
            endcase
        end
    end

    assign class_out  = class_q;
    assign class_done = done_q;

    a_r5_mgmt_top: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && cur_idx == IDX_LO && mgmt_hit) |=> (class_done && class_out == MGMT_CLASS));
    a_r2_tag_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && cur_idx == IDX_TAG && wait_q) |=> (class_done && class_out == $past(prio_field)));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> !class_done);
    a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !class_done);
    a_r9_hold_class: assert property (@(posedge clk) disable iff (!rst_n)
        !class_done |-> $stable(class_out) || $past(!rst_n));
endmodule

// File: rtl/frame_tc_classifier.sv
// Module: top of the ingress traffic-class classifier.
// Assumes one header byte per valid beat with sof/eof on the first/last byte.
// Header layout: two ADDR_BYTES addresses, a two-byte type field, then a tag.
module frame_tc_classifier #(
    parameter int CLASS_W      = 3,
    parameter int ADDR_BYTES   = 6,
    parameter int NUM_PREFIX   = 2,
    parameter int PREFIX_BYTES = 3,
    parameter logic [NUM_PREFIX*PREFIX_BYTES*8-1:0] PREFIX_LIST = 48'h01191B_0180C2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic                        in_eof,
    input  logic [tcc_pkg::BYTE_W-1:0]  in_byte,
    input  logic [tcc_pkg::TYPE_W-1:0]  cfg_vlan_type,
    input  logic [CLASS_W-1:0]          cfg_port_class,
    output logic [CLASS_W-1:0]          tc_class,
    output logic                        tc_done
);
    localparam int HI_IDX  = 2 * ADDR_BYTES;
    localparam int LO_IDX  = HI_IDX + 1;
    localparam int TAG_IDX = HI_IDX + 2;
    localparam int IDX_W   = $clog2(TAG_IDX + 1);

    logic             beat;
    logic             stop;
    logic [IDX_W-1:0] cur_idx;
    logic             mgmt_hit;
    logic             type_hit;
    logic [CLASS_W-1:0] prio_field;

    assign prio_field = in_byte[tcc_pkg::BYTE_W-1 -: CLASS_W];

    tcc_hdr_pos #(.POS_MAX(TAG_IDX)) u_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .stop(stop), .beat(beat), .cur_idx(cur_idx)
    );

    tcc_mgmt_match #(
        .NUM_PREFIX(NUM_PREFIX), .PREFIX_BYTES(PREFIX_BYTES),
        .PREFIX_LIST(PREFIX_LIST), .IDX_W(IDX_W)
    ) u_mgmt (
        .clk(clk), .rst_n(rst_n), .beat(beat), .cur_idx(cur_idx),
        .in_byte(in_byte), .hit(mgmt_hit)
    );

    tcc_type_match #(.HI_IDX(HI_IDX), .IDX_W(IDX_W)) u_type (
        .clk(clk), .rst_n(rst_n), .beat(beat), .cur_idx(cur_idx),
        .in_byte(in_byte), .cfg_type(cfg_vlan_type), .type_hit(type_hit)
    );

    tcc_class_decide #(
        .CLASS_W(CLASS_W), .LO_IDX(LO_IDX), .TAG_IDX(TAG_IDX), .IDX_W(IDX_W)
    ) u_decide (
        .clk(clk), .rst_n(rst_n), .beat(beat), .cur_idx(cur_idx),
        .in_eof(in_eof), .prio_field(prio_field), .mgmt_hit(mgmt_hit),
        .type_hit(type_hit), .cfg_default(cfg_port_class), .stop(stop),
        .class_out(tc_class), .class_done(tc_done)
    );
endmodule

// File: tb/tb_frame_tc_classifier.sv
module tb_frame_tc_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] cfg_vlan_type = 16'h8100;
    logic [2:0]  cfg_port_class = 3'd3;
    logic [2:0]  tc_class;
    logic        tc_done;

    int tests = 0, fails = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    frame_tc_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .cfg_vlan_type(cfg_vlan_type),
        .cfg_port_class(cfg_port_class), .tc_class(tc_class), .tc_done(tc_done)
    );

    // Behavioural reference model.
    logic [7:0] hdr [0:15];
    int    m_idx = 0;
    bit    m_in  = 0;
    bit    exp_done = 0;
    logic [2:0] exp_class = 3'd0;
    string exp_req = "R1";

    task automatic m_decide(input logic [2:0] c, input string r);
        exp_done = 1; exp_class = c; exp_req = r; m_in = 0;
    endtask

    always @(posedge clk) begin
        exp_done = 0;
        if (!rst_n) begin
            exp_class = 3'd0; m_in = 0; m_idx = 0; exp_req = "R1";
        end else begin
            exp_req = "R7/R9 quiet";
            if (in_valid && (in_sof || m_in)) begin
                if (in_sof) begin m_idx = 0; m_in = 1; end   // R8
                if (m_idx < 16) hdr[m_idx] = in_byte;
                if (m_idx == 13) begin
                    if ({hdr[0],hdr[1],hdr[2]} == 24'h0180C2 ||
                        {hdr[0],hdr[1],hdr[2]} == 24'h01191B)
                        m_decide(3'd7, "R5");
                    else if ({hdr[12],hdr[13]} != cfg_vlan_type)
                        m_decide(cfg_port_class, cfg_vlan_type != 16'h8100 ? "R4/R3" : "R3");
                    else if (in_eof)
                        m_decide(cfg_port_class, "R6");
                end else if (m_idx == 14) begin
                    m_decide(hdr[14][7:5], "R2");
                end else if (in_eof) begin
                    m_decide(cfg_port_class, "R6");
                end
                if (in_eof) m_in = 0;
                m_idx++;
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (checking && !finished) begin
            tests++;
            if (tc_done !== exp_done || tc_class !== exp_class) begin
                fails++;
                $display("FAIL %s: done/class actual %0b/%0d expected %0b/%0d at %0t",
                         exp_req, tc_done, tc_class, exp_done, exp_class, $time);
            end
        end
    end

    logic [7:0] fb [0:31];

    task automatic put(input logic [7:0] b, input bit sof, input bit eof);
        @(negedge clk);
        in_valid = 1; in_byte = b; in_sof = sof; in_eof = eof;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 8'hEE;
        end
    endtask

    task automatic build(input logic [23:0] oui, input logic [15:0] et, input logic [7:0] tci);
        fb[0] = oui[23:16]; fb[1] = oui[15:8]; fb[2] = oui[7:0];
        for (int i = 3; i < 12; i++) fb[i] = 8'(i * 17 + 1);
        fb[12] = et[15:8]; fb[13] = et[7:0]; fb[14] = tci;
        for (int i = 15; i < 32; i++) fb[i] = 8'(i * 29);
    endtask

    task automatic send(input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            put(fb[i], i == 0, i == len - 1);
            if (gaps && (i % 4 == 2)) idle(1);
        end
        idle(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); checking = 1;
        // R1: reset state
        tests++;
        if (tc_done !== 1'b0 || tc_class !== 3'd0) begin
            fails++;
            $display("FAIL R1: done/class actual %0b/%0d expected 0/0", tc_done, tc_class);
        end
        rst_n = 1;
        idle(2);
        // R9: stray bytes outside a frame (R7)
        put(8'h01, 0, 0); put(8'h80, 0, 1); idle(2);
        build(24'h00AABB, 16'h0800, 8'hE0); send(20, 0);   // R3 untagged
        build(24'h00AABB, 16'h8100, 8'hA0); send(20, 0);   // R2 prio 5
        build(24'h00AABB, 16'h8100, 8'h1F); send(15, 1);   // R2 prio 0, gaps
        build(24'h0180C2, 16'h8100, 8'h40); send(18, 0);   // R5
        build(24'h01191B, 16'h0800, 8'h00); send(14, 0);   // R5 minimal length
        build(24'h0180C3, 16'h0800, 8'h00); send(16, 0);   // near miss
        build(24'h00AABB, 16'h8100, 8'hC0); send(14, 0);   // R6 tagged ends at 13
        build(24'h0180C2, 16'h8100, 8'hC0); send(5, 0);    // R6 short mgmt
        send(1, 0);                                        // R6 single byte
        cfg_port_class = 3'd6; cfg_vlan_type = 16'hDADA;
        build(24'h00AABB, 16'h8100, 8'hE0); send(20, 0);   // R4
        build(24'h00AABB, 16'hDADA, 8'h60); send(20, 0);   // R2 custom
        // R8: restart mid-frame
        build(24'h00AABB, 16'hDADA, 8'h20);
        for (int i = 0; i < 9; i++) put(fb[i], i == 0, 0);
        send(17, 0);
        // back-to-back frames without gaps
        build(24'h00AABB, 16'h0800, 8'h00);
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < 16; i++) put(fb[i], i == 0, i == 15);
        idle(2);
        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [23:0] oui;
            logic [15:0] et;
            int r = int'($urandom_range(0, 9));
            oui = (r < 2) ? 24'h0180C2 : (r < 3) ? 24'h01191B : (r < 4) ? 24'h0180C3 : 24'($urandom);
            r = int'($urandom_range(0, 5));
            et = (r < 2) ? cfg_vlan_type : (r < 3) ? 16'h8100 : 16'($urandom);
            build(oui, et, 8'($urandom));
            if (n % 50 == 0) begin
                cfg_vlan_type = (n % 100 == 0) ? 16'h8100 : 16'h88A8;
                cfg_port_class = 3'($urandom);
            end
            send(int'($urandom_range(1, 24)), ($urandom_range(0, 3) == 0));
        end
        idle(4);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule